// File: doc/BRIEF.md
# Multi-buffer DMA channel sequencer

This block is the control logic for one channel of a DMA engine that moves a series of buffers, one after another. Software programs an initial source address, destination address, buffer length, mode bits and a next-descriptor pointer, then starts the channel. The sequencer offers the current source and destination addresses to an external data mover one beat at a time. It counts the beats, and at the end of each buffer it decides where the next buffer's parameters come from.

For the source and the destination separately, the next start address is either restored to its programmed value, continued from the address after the last beat, or taken from a four-word descriptor that the sequencer reads from memory. The chain ends in one of two ways. In linked mode it ends when a fetched descriptor carries a zero next pointer. In replay mode it ends when software clears the auto-repeat flag. The channel then stops and raises a chain-complete flag. A buffer-complete flag is raised at the end of every buffer. Each flag drives the interrupt line only when its mask bit is set.

Top module: `mbuf_chan_seq`

## Requirements
- R1: After reset the channel is disabled: `chan_en`, `irq`, `xfer_req` and `dsc_req` are 0, and a read of the control/status register (address 7) returns 0.
- R2: Writing 1 to bit 0 of address 7 while the channel is disabled enables it. The first buffer starts from the programmed source (address 0) and destination (address 1), unless that side is fetched. Each acknowledged beat advances both addresses by 4.
- R3: A buffer lasts for the number of beats held in the low 16 bits of the size value. A size of 0 runs exactly one beat.
- R4: At every buffer boundary the mode is decoded. It is linked when the next pointer is nonzero and either fetch enable is set (address 3, bit 1 source and bit 2 destination). It is replay when the pointer is zero, auto (address 3, bit 0) is set and neither fetch enable is set. Every other combination is single. In single, the channel stops after the buffer that just ended.
- R5: In linked mode the sequencer reads four words at pointer, pointer+4, pointer+8 and pointer+12, in that order: source, destination, size, next pointer. A fetched address is used only on a side whose fetch enable is set. Linked mode also applies at start.
- R6: A side that is not fetched takes its programmed value at a boundary when its replay bit is set (address 4, bit 0 source and bit 1 destination). When that bit is clear, the side continues from the address after its last beat.
- R7: In replay mode the size is restored to its programmed value at each boundary. Clearing auto while a buffer runs makes that buffer the last one.
- R8: Status bit 1 (buffer done) is set when the last beat of any buffer is acknowledged. Status bit 2 (chain done) is set in the same cycle that the channel stops. Status bit 0 shows the channel-enabled state.
- R9: `irq` is high exactly while a status flag is set whose mask bit is also set (address 6, bit 0 for buffer done and bit 1 for chain done).
- R10: Reading address 7 clears both flags. A flag event in the same cycle as that read stays set.
- R11: `xfer_req` and `dsc_req` are never high together, and neither is high while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on address 7) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_rd` is high |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Address of the requested descriptor word |
| dsc_ack | input | 1 | Descriptor word returned this cycle |
| dsc_data | input | 32 | Descriptor word |
| xfer_req | output | 1 | Beat request to the data mover |
| xfer_src | output | 32 | Source address of the current beat |
| xfer_dst | output | 32 | Destination address of the current beat |
| xfer_ack | input | 1 | Beat written to the destination |
| chan_en | output | 1 | Channel enabled |
| irq | output | 1 | Masked interrupt |

## Verification
The bench runs several kinds of chains. A single buffer and a zero-length buffer separate beat counting from mode decode. A three-descriptor chain with only the source fetched shows whether fetched words go only to the enabled side while the other side runs contiguously. Replay runs with restored and contiguous sides, with auto cleared during the first or a later buffer, show whether the boundary samples the live flag and stops after the right buffer. Random configurations mix all mode bits, lengths, masks and ready patterns. Each beat address and each descriptor read address is compared with a bench model. A status read timed to the last beat of a buffer separates a clear-on-read that drops the event from one that keeps it.

// File: rtl/mbseq_pkg.sv
`timescale 1ns/1ps
// Shared types and decode rules for the multi-buffer channel sequencer.
// Assumes: a single channel; register addresses are 3 bits wide.
package mbseq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_REPLAY = 2'd1,
        MODE_LINKED = 2'd2
    } chain_mode_e;

    typedef enum logic [1:0] {
        SIDE_RELOAD = 2'd0,
        SIDE_CONTIG = 2'd1,
        SIDE_FETCH  = 2'd2
    } side_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_FETCH  = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic auto_en;
        logic src_fetch;
        logic dst_fetch;
        logic src_replay;
        logic dst_replay;
    } chan_cfg_t;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_SIZE = 3'd2;
    localparam logic [2:0] REG_MODE = 3'd3;
    localparam logic [2:0] REG_CFG  = 3'd4;
    localparam logic [2:0] REG_PTR  = 3'd5;
    localparam logic [2:0] REG_MASK = 3'd6;
    localparam logic [2:0] REG_CTRL = 3'd7;

    // Chain mode from pointer state and mode bits; undefined mixes fall to single.
    function automatic chain_mode_e decode_mode(input logic ptr_zero, input chan_cfg_t c);
        if (!ptr_zero && (c.src_fetch || c.dst_fetch))
            return MODE_LINKED;
        if (ptr_zero && c.auto_en && !c.src_fetch && !c.dst_fetch)
            return MODE_REPLAY;
        return MODE_SINGLE;
    endfunction

    // Per-side source of the next start address.
    function automatic side_sel_e pick_side(input chain_mode_e m, input logic fetch_en,
                                            input logic replay_en);
        if (m == MODE_LINKED && fetch_en)
            return SIDE_FETCH;
        if (replay_en)
            return SIDE_RELOAD;
        return SIDE_CONTIG;
    endfunction

endpackage

// File: rtl/mbseq_regs.sv
`timescale 1ns/1ps
// Register file of the channel: initial values, mode bits, masks and the
// clear-on-read status flags. Produces the start pulse and the masked irq.
// Assumes: one register access per cycle; read data is combinational.
module mbseq_regs
    import mbseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [AW-1:0]    wdata,
    output logic [AW-1:0]    rdata,
    input  logic             ch_en,
    input  logic             buf_evt,
    input  logic             chain_evt,
    output logic [AW-1:0]    init_src,
    output logic [AW-1:0]    init_dst,
    output logic [CNT_W-1:0] init_size,
    output logic [AW-1:0]    init_ptr,
    output chan_cfg_t        cfg,
    output logic             start,
    output logic             flag_buf,
    output logic             flag_chain,
    output logic             irq
);

    logic [1:0] mask_q;
    logic       rd_clear;

    assign start    = wr_en && (addr == REG_CTRL) && wdata[0] && !ch_en;
    assign rd_clear = rd_en && (addr == REG_CTRL);

    // Holds the programmed channel values written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_src  <= '0;
            init_dst  <= '0;
            init_size <= '0;
            init_ptr  <= '0;
            cfg       <= '0;
            mask_q    <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_SRC:  init_src  <= wdata;
                REG_DST:  init_dst  <= wdata;
                REG_SIZE: init_size <= wdata[CNT_W-1:0];
                REG_MODE: begin
                    cfg.auto_en   <= wdata[0];
                    cfg.src_fetch <= wdata[1];
                    cfg.dst_fetch <= wdata[2];
                end
                REG_CFG: begin
                    cfg.src_replay <= wdata[0];
                    cfg.dst_replay <= wdata[1];
                end
                REG_PTR:  init_ptr  <= wdata;
                REG_MASK: mask_q    <= wdata[1:0];
                default: ;
            endcase
        end
    end

    // Sticky event flags; a read clears them unless an event lands in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_buf   <= 1'b0;
            flag_chain <= 1'b0;
        end else begin
            flag_buf   <= (flag_buf   && !rd_clear) || buf_evt;
            flag_chain <= (flag_chain && !rd_clear) || chain_evt;
        end
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                REG_SRC:  rdata = init_src;
                REG_DST:  rdata = init_dst;
                REG_SIZE: rdata = AW'(init_size);
                REG_MODE: rdata = AW'({cfg.dst_fetch, cfg.src_fetch, cfg.auto_en});
                REG_CFG:  rdata = AW'({cfg.dst_replay, cfg.src_replay});
                REG_PTR:  rdata = init_ptr;
                REG_MASK: rdata = AW'(mask_q);
                default:  rdata = AW'({flag_chain, flag_buf, ch_en});
            endcase
        end
    end

    assign irq = (flag_buf && mask_q[0]) || (flag_chain && mask_q[1]);

    AST_COR_KEEP_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && buf_evt) |=> flag_buf);   // R10
    AST_COR_KEEP_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && chain_evt) |=> flag_chain); // R10

endmodule

// File: rtl/mbseq_side.sv
`timescale 1ns/1ps
// One address side (source or destination). Loads the programmed value at
// start, applies the boundary choice, accepts a fetched descriptor word and
// steps by one beat on each acknowledged beat.
// Assumes: load, fetch, boundary update and step never coincide.
module mbseq_side
    import mbseq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] init_addr,
    input  logic          load_init,
    input  logic          bound_upd,
    input  side_sel_e     sel,
    input  logic          step,
    input  logic          fetch_we,
    input  logic [AW-1:0] fetch_data,
    output logic [AW-1:0] cur_addr
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Working address register of this side.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (load_init)
            cur_addr <= init_addr;
        else if (fetch_we)
            cur_addr <= fetch_data;
        else if (bound_upd && sel == SIDE_RELOAD)
            cur_addr <= init_addr;
        else if (step)
            cur_addr <= cur_addr + STEP_V;
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_init && !fetch_we && !bound_upd) |=> cur_addr == $past(cur_addr) + STEP_V); // R2
    AST_CONTIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_upd && sel == SIDE_CONTIG && !step && !fetch_we && !load_init) |=> $stable(cur_addr)); // R6

endmodule

// File: rtl/mbseq_ctrl.sv
`timescale 1ns/1ps
// Channel state machine: start, mode decode at each boundary, four-word
// descriptor fetch, beat counting and termination. Drives the side controls
// and the buffer/chain events.
// Assumes: dsc_data is valid in the cycle dsc_ack is high.
module mbseq_ctrl
    import mbseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  chan_cfg_t         cfg,
    input  logic [CNT_W-1:0]  init_size,
    input  logic [AW-1:0]     init_ptr,
    input  logic              dsc_ack,
    input  logic [AW-1:0]     dsc_data,
    input  logic              xfer_ack,
    output logic              ch_en,
    output logic              dsc_req,
    output logic [AW-1:0]     dsc_addr,
    output logic              xfer_req,
    output logic              buf_evt,
    output logic              chain_evt,
    output logic              load_init,
    output logic              bound_upd,
    output side_sel_e [1:0]   side_sel,
    output logic [1:0]        fetch_we,
    output logic              step
);

    localparam int WORD_BYTES = AW / 8;

    seq_state_e       state;
    logic             first_q;
    logic [1:0]       word_q;
    logic [AW-1:0]    ptr_q;
    logic [AW-1:0]    fbase_q;
    logic [CNT_W-1:0] size_q;
    logic [CNT_W-1:0] beat_q;
    chain_mode_e      mode;
    logic             stop;
    logic             last_beat;

    assign mode      = decode_mode(ptr_q == '0, cfg);
    assign stop      = (state == ST_DECIDE) && !first_q && (mode == MODE_SINGLE);
    assign last_beat = ({1'b0, beat_q} + 1'b1) >= {1'b0, size_q};

    // Main sequencing register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            first_q <= 1'b0;
            word_q  <= '0;
            ptr_q   <= '0;
            fbase_q <= '0;
            size_q  <= '0;
            beat_q  <= '0;
            ch_en   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ch_en   <= 1'b1;
                        first_q <= 1'b1;
                        ptr_q   <= init_ptr;
                        size_q  <= init_size;
                        state   <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    first_q <= 1'b0;
                    if (stop) begin
                        ch_en <= 1'b0;
                        state <= ST_IDLE;
                    end else if (mode == MODE_LINKED) begin
                        fbase_q <= ptr_q;
                        word_q  <= '0;
                        state   <= ST_FETCH;
                    end else begin
                        if (!first_q && mode == MODE_REPLAY)
                            size_q <= init_size;
                        beat_q <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_FETCH: begin
                    if (dsc_ack) begin
                        word_q <= word_q + 2'd1;
                        if (word_q == 2'd2)
                            size_q <= dsc_data[CNT_W-1:0];
                        if (word_q == 2'd3) begin
                            ptr_q  <= dsc_data;
                            beat_q <= '0;
                            state  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (xfer_ack) begin
                        if (last_beat)
                            state <= ST_DECIDE;
                        else
                            beat_q <= beat_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake requests and descriptor word address.
    always_comb begin
        dsc_req  = (state == ST_FETCH);
        xfer_req = (state == ST_RUN);
        dsc_addr = fbase_q + AW'(word_q) * AW'(WORD_BYTES);
    end

    // Side controls and events derived from the current state.
    always_comb begin
        load_init   = (state == ST_IDLE) && start;
        bound_upd   = (state == ST_DECIDE) && !first_q && !stop;
        side_sel[0] = pick_side(mode, cfg.src_fetch, cfg.src_replay);
        side_sel[1] = pick_side(mode, cfg.dst_fetch, cfg.dst_replay);
        fetch_we[0] = (state == ST_FETCH) && dsc_ack && (word_q == 2'd0) && cfg.src_fetch;
        fetch_we[1] = (state == ST_FETCH) && dsc_ack && (word_q == 2'd1) && cfg.dst_fetch;
        step        = (state == ST_RUN) && xfer_ack;
        buf_evt     = step && last_beat;
        chain_evt   = stop;
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_req && dsc_req));                 // R11
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req || dsc_req) |-> ch_en);        // R11
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ((size_q == '0) ? (beat_q == '0) : (beat_q < size_q))); // R3
    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_req && dsc_ack && word_q != 2'd3) |=> (dsc_req && word_q == $past(word_q) + 2'd1)); // R5

endmodule

// File: rtl/mbuf_chan_seq.sv
`timescale 1ns/1ps
// Top of the multi-buffer channel sequencer: register file, state machine
// and one address side per direction (index 0 source, 1 destination).
// Assumes: an external data mover performs each beat and acknowledges it.
module mbuf_chan_seq
    import mbseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16,
    parameter int STEP  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          dsc_req,
    output logic [AW-1:0] dsc_addr,
    input  logic          dsc_ack,
    input  logic [AW-1:0] dsc_data,
    output logic          xfer_req,
    output logic [AW-1:0] xfer_src,
    output logic [AW-1:0] xfer_dst,
    input  logic          xfer_ack,
    output logic          chan_en,
    output logic          irq
);

    localparam int NSIDE = 2;

    logic [AW-1:0]    init_src, init_dst, init_ptr;
    logic [CNT_W-1:0] init_size;
    chan_cfg_t        cfg;
    logic             start, buf_evt, chain_evt, flag_buf, flag_chain;
    logic             load_init, bound_upd, step;
    side_sel_e [1:0]  side_sel;
    logic [1:0]       fetch_we;
    logic [AW-1:0]    side_init [NSIDE];
    logic [AW-1:0]    side_cur  [NSIDE];

    mbseq_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ch_en(chan_en), .buf_evt(buf_evt),
        .chain_evt(chain_evt), .init_src(init_src), .init_dst(init_dst),
        .init_size(init_size), .init_ptr(init_ptr), .cfg(cfg), .start(start),
        .flag_buf(flag_buf), .flag_chain(flag_chain), .irq(irq)
    );

    mbseq_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .init_size(init_size),
        .init_ptr(init_ptr), .dsc_ack(dsc_ack), .dsc_data(dsc_data),
        .xfer_ack(xfer_ack), .ch_en(chan_en), .dsc_req(dsc_req), .dsc_addr(dsc_addr),
        .xfer_req(xfer_req), .buf_evt(buf_evt), .chain_evt(chain_evt),
        .load_init(load_init), .bound_upd(bound_upd), .side_sel(side_sel),
        .fetch_we(fetch_we), .step(step)
    );

    assign side_init[0] = init_src;
    assign side_init[1] = init_dst;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        mbseq_side #(.AW(AW), .STEP(STEP)) u_side (
            .clk(clk), .rst_n(rst_n), .init_addr(side_init[g]), .load_init(load_init),
            .bound_upd(bound_upd), .sel(side_sel[g]), .step(step),
            .fetch_we(fetch_we[g]), .fetch_data(dsc_data), .cur_addr(side_cur[g])
        );
    end

    assign xfer_src = side_cur[0];
    assign xfer_dst = side_cur[1];

    AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_en) |-> flag_chain);          // R8

endmodule

// File: tb/mbuf_chan_seq_tb.sv
`timescale 1ns/1ps
module mbuf_chan_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dsc_req, dsc_ack = 1'b0;
    logic [31:0] dsc_addr, dsc_data = '0;
    logic        xfer_req, xfer_ack = 1'b0;
    logic [31:0] xfer_src, xfer_dst;
    logic        chan_en, irq;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] dmem [0:63];
    logic [31:0] exp_src [0:15];
    logic [31:0] exp_dst [0:15];
    int          exp_len [0:15];
    logic [31:0] exp_fa  [0:63];
    int          exp_n, exp_nf;

    always #2.5 clk = ~clk;

    mbuf_chan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsc_req(dsc_req), .dsc_addr(dsc_addr),
        .dsc_ack(dsc_ack), .dsc_data(dsc_data), .xfer_req(xfer_req), .xfer_src(xfer_src),
        .xfer_dst(xfer_dst), .xfer_ack(xfer_ack), .chan_en(chan_en), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Bench mode rule: 2 linked, 1 replay, 0 single.
    function automatic int bmode(bit pz, bit sf, bit df, bit au);
        if (!pz && (sf || df)) return 2;
        if (pz && au && !sf && !df) return 1;
        return 0;
    endfunction

    // Expected buffer and fetch sequence from the requirements.
    task automatic build_model(input logic [31:0] s0, d0, input int l0, input logic [31:0] p0,
                               input bit au, sf, df, sr, dr, input int clr_at);
        logic [31:0] ws = s0, wd = d0, wp = p0;
        int wl = l0, eff, m;
        bit first = 1'b1, au_now;
        exp_n = 0; exp_nf = 0;
        while (exp_n < 16) begin
            au_now = au && !(exp_n > clr_at);
            m = bmode(wp == 0, sf, df, au_now);
            if (!first && m == 0) break;
            if (!first) begin
                if (!(m == 2 && sf) && sr) ws = s0;
                if (!(m == 2 && df) && dr) wd = d0;
            end
            if (m == 2) begin
                for (int k = 0; k < 4; k++) exp_fa[exp_nf + k] = wp + 32'(4 * k);
                exp_nf += 4;
                if (sf) ws = dmem[wp[7:2]];
                if (df) wd = dmem[wp[7:2] + 6'd1];
                wl = int'(dmem[wp[7:2] + 6'd2] & 32'hFFFF);
                wp = dmem[wp[7:2] + 6'd3];
            end else if (!first && m == 1) begin
                wl = l0;
            end
            eff = (wl == 0) ? 1 : wl;
            exp_src[exp_n] = ws; exp_dst[exp_n] = wd; exp_len[exp_n] = eff;
            exp_n++;
            ws += 32'(4 * eff); wd += 32'(4 * eff);
            first = 1'b0;
        end
    endtask

    task automatic run_scen(input string nm, input logic [31:0] s0, d0, input int l0,
                            input logic [31:0] p0, input bit au, sf, df, sr, dr,
                            input logic [1:0] mask, input int clr_at, input bit rd_corner);
        int bi = 0, bj = 0, fc = 0, ovl = 0, irq_bad = 0, cyc = 0;
        logic [31:0] st;
        wr(3'd0, s0); wr(3'd1, d0); wr(3'd2, 32'(l0)); wr(3'd3, {29'd0, df, sf, au});
        wr(3'd4, {30'd0, dr, sr}); wr(3'd5, p0); wr(3'd6, {30'd0, mask});
        build_model(s0, d0, l0, p0, au, sf, df, sr, dr, clr_at);
        wr(3'd7, 32'd1);
        while (1) begin
            @(negedge clk);
            dsc_ack = 1'b0; xfer_ack = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
            cyc++;
            if (!chan_en || cyc > 3000) break;
            if (xfer_req && dsc_req) ovl++;
            if (mask == 2'b00 && irq) irq_bad++;
            if (dsc_req && ($urandom % 2 == 0)) begin
                chk(fc < exp_nf && dsc_addr == exp_fa[fc & 63], {"R5 fetch address ", nm}, dsc_addr, exp_fa[fc & 63]);
                dsc_ack = 1'b1; dsc_data = dmem[dsc_addr[7:2]]; fc++;
            end
            if (xfer_req && ($urandom % 4 != 0)) begin
                if (bi < exp_n) begin
                    chk(xfer_src == exp_src[bi] + 32'(4 * bj), {"R6 source beat ", nm}, xfer_src, exp_src[bi] + 32'(4 * bj));
                    chk(xfer_dst == exp_dst[bi] + 32'(4 * bj), {"R2 destination beat ", nm}, xfer_dst, exp_dst[bi] + 32'(4 * bj));
                    if (bi == clr_at && bj == 0 && au) begin
                        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = {29'd0, df, sf, 1'b0};
                    end
                    if (rd_corner && bi == 0 && bj == exp_len[0] - 1) begin
                        reg_rd = 1'b1; reg_addr = 3'd7;
                    end
                    bj++;
                    if (bj == exp_len[bi]) begin bi++; bj = 0; end
                end else begin
                    chk(1'b0, {"R4 extra buffer ", nm}, 32'(bi), 32'(exp_n));
                    bi++;
                end
                xfer_ack = 1'b1;
            end
        end
        chk(cyc <= 3000, {"R4 channel stop ", nm}, 32'(cyc), 32'd3000);
        chk(bi == exp_n && bj == 0, {"R4 R7 buffer count ", nm}, 32'(bi), 32'(exp_n));
        chk(fc == exp_nf, {"R5 fetch count ", nm}, 32'(fc), 32'(exp_nf));
        chk(ovl == 0, {"R11 request overlap ", nm}, 32'(ovl), 32'd0);
        chk(irq_bad == 0, {"R9 irq while masked ", nm}, 32'(irq_bad), 32'd0);
        chk(irq == (mask != 2'b00), {"R9 irq at end ", nm}, {31'd0, irq}, {31'd0, mask != 2'b00});
        rd(3'd7, st);
        chk(st == 32'd6, {"R8 R10 status after stop ", nm}, st, 32'd6);
        rd(3'd7, st);
        chk(st == 32'd0, {"R10 status after read ", nm}, st, 32'd0);
        chk(irq == 1'b0, {"R9 irq after clear ", nm}, {31'd0, irq}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] st;
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk(!chan_en && !irq && !xfer_req && !dsc_req, "R1 outputs after reset",
            {28'd0, chan_en, irq, xfer_req, dsc_req}, 32'd0);
        rd(3'd7, st);
        chk(st == 32'd0, "R1 status after reset", st, 32'd0);

        // R2 R3 R10: single buffer, read of status timed on the last beat
        run_scen("single", 32'h0000_0100, 32'h0000_0200, 3, 0, 0, 0, 0, 0, 0, 2'b00, 99, 1);
        // R3: size zero runs one beat
        run_scen("size0", 32'h0000_0400, 32'h0000_0800, 0, 0, 0, 0, 0, 0, 0, 2'b01, 99, 0);
        // R5 R6: three descriptors, source fetched, destination contiguous
        for (int j = 0; j < 3; j++) begin
            dmem[4 * (j + 1) + 0] = 32'h2000_0000 + 32'(j * 256);
            dmem[4 * (j + 1) + 1] = 32'h5555_0000;
            dmem[4 * (j + 1) + 2] = 32'(j + 1);
            dmem[4 * (j + 1) + 3] = (j < 2) ? 32'(16 * (j + 2)) : 32'd0;
        end
        run_scen("linked", 32'h0000_1000, 32'h0000_3000, 2, 32'd16, 0, 1, 0, 0, 0, 2'b10, 99, 0);
        // R7: replay with both sides restored, auto cleared during buffer 2
        run_scen("replay3", 32'h0000_0A00, 32'h0000_0B00, 2, 0, 1, 0, 0, 1, 1, 2'b11, 2, 0);
        // R7 R6: auto cleared during the first buffer; destination contiguous
        run_scen("replay1", 32'h0000_0C00, 32'h0000_0D00, 1, 0, 1, 0, 0, 1, 0, 2'b01, 0, 0);
        // R4: fetch enabled with a zero pointer falls back to single
        run_scen("fetch_ptr0", 32'h0000_0E00, 32'h0000_0F00, 2, 0, 0, 1, 1, 0, 0, 2'b00, 99, 0);
        // R4 R6: replay with contiguous sides for several buffers
        run_scen("replay_contig", 32'h0000_1100, 32'h0000_1200, 3, 0, 1, 0, 0, 0, 0, 2'b10, 2, 0);

        for (int t = 0; t < 24; t++) begin
            int k;
            bit sf, df, sr, dr, au;
            k = 1 + int'($urandom % 3);
            for (int i = 0; i < 64; i++) dmem[i] = '0;
            for (int j = 0; j < k; j++) begin
                dmem[4 * (j + 1) + 0] = 32'h4000_0000 + 32'(($urandom % 64) * 64);
                dmem[4 * (j + 1) + 1] = 32'h6000_0000 + 32'(($urandom % 64) * 64);
                dmem[4 * (j + 1) + 2] = 32'($urandom % 5);
                dmem[4 * (j + 1) + 3] = (j < k - 1) ? 32'(16 * (j + 2)) : 32'd0;
            end
            sf = bit'($urandom % 2); df = bit'($urandom % 2);
            sr = bit'($urandom % 2); dr = bit'($urandom % 2);
            au = bit'($urandom % 2);
            run_scen($sformatf("rand%0d", t),
                     32'h1000_0000 + 32'(($urandom % 16) * 64),
                     32'h3000_0000 + 32'(($urandom % 16) * 64),
                     int'($urandom % 5), ($urandom % 3 == 0) ? 32'd0 : 32'd16,
                     au, sf, df, sr, dr, 2'($urandom % 4), int'($urandom % 3), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule